// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block compares a 16-bit internal address bus against a programmed breakpoint address and requests a break interrupt when they agree. The breakpoint address is held in two byte-wide registers. Every address counts, whether the processor or the DMA engine issues it, as long as one of the two strobes marks it valid and breaks are enabled. Software can also force a break by writing the active bit of the control register.

A break is not taken at once. It stays pending until the instruction in progress ends, which an instruction-boundary pulse marks. The block then raises its request for one cycle and presents the interrupt vector address with it. The vector has a normal value and a monitor-mode value.

A sticky stop/wait flag records breaks that occur while the system sleeps, and a wake output asks the system to leave stop mode. Registers are reached through a small byte-wide bus with a 2-bit select.

Top module: `brkpt_ctl`

## Requirements
- R1: After reset, all four registers read 0x00, and `brk_req`, `brk_vector` and `wake_req` are 0.
- R2: The register select picks one register: select 0 is the address high byte (bits 15:8), select 1 is the low byte (bits 7:0), select 2 is control and select 3 is the flag. In the control register, bit 7 is enable, bit 6 is active, and bits 5:0 always read 0. In the flag register, only bit 0 is used. Reads are combinational, and a write takes effect at the clock edge on which `reg_wr` is high.
- R3: An address counts as a match only when all 16 bits equal the programmed value, `cpu_valid` or `dma_valid` is high, and enable is 1. Any single differing bit, or no strobe, means no match.
- R4: A match sets the active bit. It reads back as 1 from the next cycle on.
- R5: Writing control with bit 6 = 1 forces a pending break without any address match. Writing bit 6 = 0 clears the active bit.
- R6: A control-register write in the same cycle as an address match wins: the match is dropped, and no break follows.
- R7: A break stays pending until the first cycle with `insn_end` high. `brk_req` is then high for exactly the next cycle. Further matches or forces while a break is pending produce no extra request.
- R8: With `brk_req`, `brk_vector` is 0xFFFC, or 0xFEFC if `monitor_mode` was high in the boundary cycle. Otherwise it is 0x0000.
- R9: `wake_req` is high while a break is pending and `stop_mode` is high. A break that becomes pending during stop mode sets the flag.
- R10: In wait mode, the flag is set by a qualified match that has `dma_valid` high, or by a control write with `reg_from_dma` high. A processor-only match in wait mode leaves the flag alone.
- R11: Once set, the flag stays set until reset or until a write of 0 to flag bit 0. Writing 1 does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Internal address bus |
| cpu_valid | input | 1 | Address issued by the processor |
| dma_valid | input | 1 | Address issued by the DMA engine |
| insn_end | input | 1 | Instruction-boundary pulse |
| monitor_mode | input | 1 | Selects the monitor-mode vector |
| stop_mode | input | 1 | System is in stop mode |
| wait_mode | input | 1 | System is in wait mode |
| reg_wr | input | 1 | Register write strobe |
| reg_from_dma | input | 1 | The current register write comes from DMA |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| brk_req | output | 1 | One-cycle breakpoint request |
| brk_vector | output | 16 | Vector address presented with the request |
| wake_req | output | 1 | Request to leave stop mode |

## Verification
A wrong comparator or enable state shows up one cycle after the offending address, as a wrong active bit in the control register. A wrong pending state shows up at the next instruction boundary, as a missing, doubled or early `brk_req`, or as a wrong vector beside it. Flag errors can be read through select 3 on the cycle after the event. They persist until cleared, so a missing or spurious set is never masked.

// File: rtl/brkpt_ctl.sv
module brkpt_ctl #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] VEC_NORM = 16'hFFFC,
  parameter logic [15:0] VEC_MON  = 16'hFEFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          cpu_valid,
  input  logic          dma_valid,
  input  logic          insn_end,
  input  logic          monitor_mode,
  input  logic          stop_mode,
  input  logic          wait_mode,
  input  logic          reg_wr,
  input  logic          reg_from_dma,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          brk_req,
  output logic [AW-1:0] brk_vector,
  output logic          wake_req
);
  localparam int HW = AW / 2;

  logic [HW-1:0] hi_q, lo_q;
  logic en_q, act_q, pend_q, flag_q;

  wire wr_hi   = reg_wr && reg_sel == 2'd0;
  wire wr_lo   = reg_wr && reg_sel == 2'd1;
  wire wr_ctrl = reg_wr && reg_sel == 2'd2;
  wire wr_flag = reg_wr && reg_sel == 2'd3;

  wire hi_eq = bus_addr[AW-1:HW] == hi_q;
  wire lo_eq = bus_addr[HW-1:0]  == lo_q;
  wire hit   = hi_eq && lo_eq && (cpu_valid || dma_valid) && en_q && !wr_ctrl;
  wire force_brk = wr_ctrl && reg_wdata[6];
  wire arm   = (hit || force_brk) && !pend_q;
  wire flag_set = (arm && stop_mode) ||
                  (wait_mode && ((hit && dma_valid) || (wr_ctrl && reg_from_dma)));

  assign wake_req = pend_q && stop_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi) hi_q <= reg_wdata[HW-1:0];
      if (wr_lo) lo_q <= reg_wdata[HW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      act_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= reg_wdata[7];
      act_q <= reg_wdata[6];
    end else if (hit) begin
      act_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      brk_req    <= 1'b0;
      brk_vector <= '0;
    end else begin
      pend_q     <= pend_q ? !insn_end : arm;
      brk_req    <= pend_q && insn_end;
      brk_vector <= (pend_q && insn_end) ? (monitor_mode ? VEC_MON : VEC_NORM) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag_q <= 1'b0;
    else if (flag_set)                 flag_q <= 1'b1;
    else if (wr_flag && !reg_wdata[0]) flag_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0:    reg_rdata[HW-1:0] = hi_q;
      2'd1:    reg_rdata[HW-1:0] = lo_q;
      2'd2:    reg_rdata[7:6]    = {en_q, act_q};
      default: reg_rdata[0]      = flag_q;
    endcase
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req); // R7
  AST_VECTOR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_vector == VEC_NORM || brk_vector == VEC_MON)); // R8
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> brk_vector == '0); // R8
  AST_HIT_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> reg_sel != 2'd2 || reg_rdata[6]); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !force_brk) |=> !$rose(pend_q)); // R3
  AST_CTRL_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reg_wdata[6]) |=> !act_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_flag && !reg_wdata[0])) |=> flag_q); // R11
endmodule

// File: tb/brkpt_ctl_tb_top.sv
module brkpt_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 0;
  logic cpu_valid = 0, dma_valid = 0, insn_end = 0, monitor_mode = 0;
  logic stop_mode = 0, wait_mode = 0, reg_wr = 0, reg_from_dma = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic brk_req, wake_req;
  logic [15:0] brk_vector;
  int errors = 0, checks = 0;
  localparam logic [15:0] TGT = 16'h1234;

  always #2 clk = ~clk;

  brkpt_ctl dut_i (.*);

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d, logic from_dma);
    reg_wr = 1; reg_sel = sel; reg_wdata = d; reg_from_dma = from_dma;
    tick;
    reg_wr = 0; reg_from_dma = 0;
  endtask

  task automatic rd(string req, logic [1:0] sel, logic [7:0] exp);
    reg_sel = sel; #1;
    check(req, {8'h0, reg_rdata}, {8'h0, exp});
  endtask

  task automatic present(logic [15:0] a, logic c, logic d);
    bus_addr = a; cpu_valid = c; dma_valid = d;
    tick;
    cpu_valid = 0; dma_valid = 0;
  endtask

  task automatic boundary;
    insn_end = 1; tick; insn_end = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    for (int s = 0; s < 4; s++) rd("R1 reset reg", 2'(s), 8'h00);
    check("R1 reset req", {15'h0, brk_req}, 16'h0);
    check("R1 reset vec", brk_vector, 16'h0);
    rst_n = 1; tick;
    wr(0, TGT[15:8], 0); wr(1, TGT[7:0], 0);
    rd("R2 high", 0, 8'h12); rd("R2 low", 1, 8'h34);
    present(TGT, 1, 0);
    rd("R3 disabled", 2, 8'h00);
    boundary; check("R3 no req when disabled", {15'h0, brk_req}, 16'h0);
    wr(2, 8'hBF, 0);
    rd("R2 ctrl low bits zero", 2, 8'h80);
    wr(3, 8'hFE, 0); rd("R2 flag", 3, 8'h00);
    for (int b = 0; b < 16; b++) begin
      present(TGT ^ (16'h1 << b), 1, 1);
      rd("R3 bit flip", 2, 8'h80);
    end
    present(TGT, 0, 0);
    rd("R3 no strobe", 2, 8'h80);
    present(TGT, 1, 0);
    rd("R4 active", 2, 8'hC0);
    check("R7 held until boundary", {15'h0, brk_req}, 16'h0);
    check("R9 no wake outside stop", {15'h0, wake_req}, 16'h0);
    present(TGT, 0, 1);
    boundary;
    check("R7 req", {15'h0, brk_req}, 16'h1);
    check("R8 normal vector", brk_vector, 16'hFFFC);
    tick;
    check("R7 one cycle", {15'h0, brk_req}, 16'h0);
    check("R8 idle vector", brk_vector, 16'h0);
    boundary;
    check("R7 repeat ignored", {15'h0, brk_req}, 16'h0);
    wr(2, 8'h80, 0); rd("R5 clear active", 2, 8'h80);
    wr(2, 8'hC0, 0); rd("R5 force", 2, 8'hC0);
    monitor_mode = 1; boundary; monitor_mode = 0;
    check("R5 forced req", {15'h0, brk_req}, 16'h1);
    check("R8 monitor vector", brk_vector, 16'hFEFC);
    wr(2, 8'h80, 0);
    bus_addr = TGT; cpu_valid = 1; wr(2, 8'h80, 0); cpu_valid = 0;
    rd("R6 write wins active", 2, 8'h80);
    boundary; check("R6 no req", {15'h0, brk_req}, 16'h0);
    stop_mode = 1;
    present(TGT, 1, 0);
    check("R9 wake", {15'h0, wake_req}, 16'h1);
    rd("R9 stop flag", 3, 8'h01);
    boundary; stop_mode = 0;
    check("R9 req in stop", {15'h0, brk_req}, 16'h1);
    check("R9 wake drops", {15'h0, wake_req}, 16'h0);
    wr(2, 8'h80, 0);
    wr(3, 8'h01, 0); rd("R11 write one keeps", 3, 8'h01);
    tick; rd("R11 sticky", 3, 8'h01);
    wr(3, 8'h00, 0); rd("R11 write zero clears", 3, 8'h00);
    wait_mode = 1;
    present(TGT, 1, 0);
    rd("R10 cpu match no flag", 3, 8'h00);
    boundary; wr(2, 8'h80, 0);
    present(TGT, 0, 1);
    rd("R10 dma match flag", 3, 8'h01);
    boundary; wr(2, 8'h80, 0); wr(3, 8'h00, 0);
    wr(2, 8'h80, 1);
    rd("R10 dma ctrl write flag", 3, 8'h01);
    wait_mode = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule